// File: doc/BRIEF.md
# Packed Lane Compare and Select Unit

This unit executes packed compare and select operations on 32-bit operands. A compare splits both sources into lanes and tests every lane pair. The lanes are either four unsigned bytes or two signed halfwords. The test is equality, less-than or less-or-equal. Depending on the operation code, the per-lane outcome bits go to one of three places:

- a 4-bit condition field held inside a 32-bit control register;
- a result port;
- both of these.

A later select operation reads the stored condition field. It builds each result lane from the first or the second source according to that lane's condition bit. Compare and select can therefore be chained across instructions.

Each operation enters on a single-cycle strobe. The strobe carries a 5-bit operation code, a 5-bit destination index and the two sources. The result, its destination index and a result-valid strobe appear one clock later, together with the updated control register. An operation code that the unit does not recognise raises a one-cycle reserved-instruction pulse and changes no state.

Top module: `simd_cmp_pick`

## Requirements
- R1: Byte compares treat lane i as the unsigned value at bits 8i+7..8i of each source. The relation is selected by operation-code bits [1:0]: 0 means equal, 1 means first source less than second, 2 means less-or-equal.
- R2: Halfword compares treat lane i (bits 16i+15..16i) as a signed two's-complement value and use the same relation encoding as R1.
- R3: Flag-only compares update the control register. Codes 0x00, 0x01 and 0x02 are the byte forms; codes 0x08, 0x09 and 0x0A are the halfword forms. The outcome of lane i goes to control bit 24+i and no result strobe is produced, whatever the destination index. The halfword forms write only bits 24 and 25; bits 26 and 27 keep their old values.
- R4: Result-only byte compares use codes 0x04, 0x05 and 0x06. They put the outcome of lane i in result bit i, drive result bits 31..4 to zero, and leave the control register unchanged.
- R5: Combined byte compares use codes 0x18, 0x19 and 0x1A. They give the same 4-bit result as R4 and also load control bits 27..24 with those same 4 bits.
- R6: Select has a byte form (code 0x03) and a halfword form (code 0x0B). Each result lane is taken from the first source when control bit 24+i is 1, and from the second source when it is 0.
- R7: A destination index of 0 turns the result-writing operations into no-ops. These are codes 0x03, 0x04-0x06, 0x0B and 0x18-0x1A. For them, index 0 gives no result strobe and no change to the control register.
- R8: Reset clears the whole control register, the result strobe and the reserved pulse. Control bits outside 27..24 are never changed by any operation.
- R9: Results are due one clock after the operation strobe, with a single-cycle result strobe. The result port echoes the destination index. A cycle with no operation strobe produces no strobe and changes no state.
- R10: Every other operation code asserts the reserved-instruction pulse one clock later. It produces no result strobe and leaves the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 5 | Operation code |
| op_dest_i | input | 5 | Destination index |
| op_a_i | input | 32 | First source |
| op_b_i | input | 32 | Second source |
| res_valid_o | output | 1 | Result strobe |
| res_dest_o | output | 5 | Destination index of the result |
| res_data_o | output | 32 | Result value |
| rsvd_o | output | 1 | Reserved-instruction pulse |
| ctrl_o | output | 32 | Control register, condition field at bits 27..24 |

## Verification
Every effect of an operation is registered, so the result strobe, result value, destination echo, reserved pulse and control-register update are all due at the first rising edge after the strobe. The bench drives an operation on a falling edge and drops the strobe on the next falling edge. It compares all outputs at that second falling edge, half a cycle after the registering edge. A select issued right after a compare sees the condition bits that the compare left. Because of this, the bench's own copy of the condition field is updated in the same order, one operation at a time.

// File: rtl/cp_pkg.sv
package cp_pkg;

    localparam int unsigned CP_CODE_W = 5;

    typedef enum logic [1:0] {
        REL_EQ   = 2'd0,
        REL_LT   = 2'd1,
        REL_LE   = 2'd2,
        REL_NONE = 2'd3
    } cp_rel_e;

    typedef enum logic [2:0] {
        K_RSVD,
        K_FLAG_B,
        K_FLAG_H,
        K_GET_B,
        K_BOTH_B,
        K_PICK_B,
        K_PICK_H
    } cp_kind_e;

    function automatic cp_kind_e cp_decode(input logic [CP_CODE_W-1:0] code);
        cp_kind_e k;
        case (code)
            5'h00, 5'h01, 5'h02: k = K_FLAG_B;
            5'h08, 5'h09, 5'h0A: k = K_FLAG_H;
            5'h04, 5'h05, 5'h06: k = K_GET_B;
            5'h18, 5'h19, 5'h1A: k = K_BOTH_B;
            5'h03:               k = K_PICK_B;
            5'h0B:               k = K_PICK_H;
            default:             k = K_RSVD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/cp_lane_cmp.sv
module cp_lane_cmp #(
    parameter int LANE_W       = 8,
    parameter int LANES        = 4,
    parameter bit SIGNED_LANES = 1'b0
) (
    input  logic [LANE_W*LANES-1:0] a_i,
    input  logic [LANE_W*LANES-1:0] b_i,
    input  cp_pkg::cp_rel_e         rel_i,
    output logic [LANES-1:0]        hit_o
);
    import cp_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] av, bv;
        logic              is_eq, is_lt;
        assign av    = a_i[g*LANE_W +: LANE_W];
        assign bv    = b_i[g*LANE_W +: LANE_W];
        assign is_eq = (av == bv);
        if (SIGNED_LANES) begin : g_s
            assign is_lt = ($signed(av) < $signed(bv));
        end else begin : g_u
            assign is_lt = (av < bv);
        end
        always_comb begin
            case (rel_i)
                REL_EQ:  hit_o[g] = is_eq;
                REL_LT:  hit_o[g] = is_lt;
                REL_LE:  hit_o[g] = is_lt | is_eq;
                default: hit_o[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/cp_lane_pick.sv
module cp_lane_pick #(
    parameter int LANE_W = 8,
    parameter int LANES  = 4
) (
    input  logic [LANE_W*LANES-1:0] a_i,
    input  logic [LANE_W*LANES-1:0] b_i,
    input  logic [LANES-1:0]        sel_i,
    output logic [LANE_W*LANES-1:0] y_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign y_o[g*LANE_W +: LANE_W] = sel_i[g] ? a_i[g*LANE_W +: LANE_W]
                                                  : b_i[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/simd_cmp_pick.sv
module simd_cmp_pick #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16,
    parameter int CC_LSB = 24,
    parameter int CC_W   = 4,
    parameter int IDX_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         op_valid_i,
    input  logic [cp_pkg::CP_CODE_W-1:0] op_code_i,
    input  logic [IDX_W-1:0]             op_dest_i,
    input  logic [DATA_W-1:0]            op_a_i,
    input  logic [DATA_W-1:0]            op_b_i,
    output logic                         res_valid_o,
    output logic [IDX_W-1:0]             res_dest_o,
    output logic [DATA_W-1:0]            res_data_o,
    output logic                         rsvd_o,
    output logic [DATA_W-1:0]            ctrl_o
);
    import cp_pkg::*;

    localparam int N_B = DATA_W / BYTE_W;
    localparam int N_H = DATA_W / HALF_W;
    localparam logic [DATA_W-1:0] CC_MASK = {{(DATA_W-CC_W){1'b0}}, {CC_W{1'b1}}} << CC_LSB;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic              vld;
        logic [IDX_W-1:0]  dest;
        logic [DATA_W-1:0] data;
        logic              rsvd;
    } cp_state_t;

    cp_state_t st_d, st_q;

    cp_kind_e          kind;
    cp_rel_e           rel;
    logic [N_B-1:0]    hit_b;
    logic [N_H-1:0]    hit_h;
    logic [CC_W-1:0]   cc_q;
    logic [DATA_W-1:0] pick_b, pick_h;
    logic              dest_ok;

    assign kind    = cp_decode(op_code_i);
    assign rel     = cp_rel_e'(op_code_i[1:0]);
    assign cc_q    = st_q.ctrl[CC_LSB +: CC_W];
    assign dest_ok = (op_dest_i != '0);

    cp_lane_cmp #(.LANE_W(BYTE_W), .LANES(N_B), .SIGNED_LANES(1'b0)) u_cmp_b (
        .a_i(op_a_i), .b_i(op_b_i), .rel_i(rel), .hit_o(hit_b));

    cp_lane_cmp #(.LANE_W(HALF_W), .LANES(N_H), .SIGNED_LANES(1'b1)) u_cmp_h (
        .a_i(op_a_i), .b_i(op_b_i), .rel_i(rel), .hit_o(hit_h));

    cp_lane_pick #(.LANE_W(BYTE_W), .LANES(N_B)) u_pick_b (
        .a_i(op_a_i), .b_i(op_b_i), .sel_i(cc_q[N_B-1:0]), .y_o(pick_b));

    cp_lane_pick #(.LANE_W(HALF_W), .LANES(N_H)) u_pick_h (
        .a_i(op_a_i), .b_i(op_b_i), .sel_i(cc_q[N_H-1:0]), .y_o(pick_h));

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.rsvd = 1'b0;
        if (op_valid_i) begin
            case (kind)
                K_FLAG_B: st_d.ctrl[CC_LSB +: N_B] = hit_b;
                K_FLAG_H: st_d.ctrl[CC_LSB +: N_H] = hit_h;
                K_GET_B, K_BOTH_B: begin
                    if (dest_ok) begin
                        st_d.vld            = 1'b1;
                        st_d.dest           = op_dest_i;
                        st_d.data           = '0;
                        st_d.data[N_B-1:0]  = hit_b;
                        if (kind == K_BOTH_B) st_d.ctrl[CC_LSB +: N_B] = hit_b;
                    end
                end
                K_PICK_B, K_PICK_H: begin
                    if (dest_ok) begin
                        st_d.vld  = 1'b1;
                        st_d.dest = op_dest_i;
                        st_d.data = (kind == K_PICK_B) ? pick_b : pick_h;
                    end
                end
                default: st_d.rsvd = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid_o = st_q.vld;
    assign res_dest_o  = st_q.dest;
    assign res_data_o  = st_q.data;
    assign rsvd_o      = st_q.rsvd;
    assign ctrl_o      = st_q.ctrl;

    // R7: a result strobe never carries destination index 0
    a_r7_no_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_dest_o != '0));

    // R10: a reserved code leaves the control register as it was
    a_r10_rsvd_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && kind == K_RSVD) |=> (rsvd_o && !res_valid_o && ctrl_o == $past(ctrl_o)));

    // R8: bits outside the condition field stay at their reset value
    a_r8_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_o & ~CC_MASK) == '0));

    // R3: halfword flag compares keep the upper condition bits
    a_r3_half_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && kind == K_FLAG_H) |=>
            (ctrl_o[CC_LSB+CC_W-1 : CC_LSB+N_H] == $past(ctrl_o[CC_LSB+CC_W-1 : CC_LSB+N_H])
             && !res_valid_o));

    // R4: result-only compares return a zero-extended lane mask and keep control
    a_r4_get_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && kind == K_GET_B && dest_ok) |=>
            (res_valid_o && res_data_o[DATA_W-1:N_B] == '0 && ctrl_o == $past(ctrl_o)));

    // R5: combined compares load the condition field with the returned mask
    a_r5_both_match: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && kind == K_BOTH_B && dest_ok) |=>
            (res_valid_o && ctrl_o[CC_LSB +: N_B] == res_data_o[N_B-1:0]));

    // R9: no strobe in, nothing out
    a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!res_valid_o && !rsvd_o && $stable(ctrl_o)));

endmodule

// File: tb/tb_simd_cmp_pick.sv
module tb_simd_cmp_pick;

    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [4:0]  op_dest = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        res_valid, rsvd;
    logic [4:0]  res_dest;
    logic [31:0] res_data, ctrl;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0] mcc = '0;

    always #(CLK_P/2) clk = ~clk;

    simd_cmp_pick dut (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
        .op_dest_i(op_dest), .op_a_i(op_a), .op_b_i(op_b),
        .res_valid_o(res_valid), .res_dest_o(res_dest), .res_data_o(res_data),
        .rsvd_o(rsvd), .ctrl_o(ctrl));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_b(input logic [31:0] a, input logic [31:0] b, input logic [1:0] r);
        logic [3:0] m;
        for (int i = 0; i < 4; i++) begin
            int unsigned x, y;
            x = a[8*i +: 8];
            y = b[8*i +: 8];
            m[i] = (r == 2'd0) ? (x == y) : (r == 2'd1) ? (x < y) : (x <= y);
        end
        return m;
    endfunction

    function automatic logic [1:0] ref_h(input logic [31:0] a, input logic [31:0] b, input logic [1:0] r);
        logic [1:0] m;
        for (int i = 0; i < 2; i++) begin
            int x, y;
            x = $signed(a[16*i +: 16]);
            y = $signed(b[16*i +: 16]);
            m[i] = (r == 2'd0) ? (x == y) : (r == 2'd1) ? (x < y) : (x <= y);
        end
        return m;
    endfunction

    task automatic run_op(input logic [4:0] code, input logic [4:0] dest,
                          input logic [31:0] a, input logic [31:0] b, input string tag);
        logic        ev, er;
        logic [31:0] ed;
        ev = 1'b0; er = 1'b0; ed = '0;
        case (code)
            5'h00, 5'h01, 5'h02: mcc = ref_b(a, b, code[1:0]);
            5'h08, 5'h09, 5'h0A: mcc[1:0] = ref_h(a, b, code[1:0]);
            5'h04, 5'h05, 5'h06: if (dest != 0) begin ev = 1; ed = {28'd0, ref_b(a, b, code[1:0])}; end
            5'h18, 5'h19, 5'h1A: if (dest != 0) begin
                ev = 1; ed = {28'd0, ref_b(a, b, code[1:0])}; mcc = ed[3:0];
            end
            5'h03: if (dest != 0) begin
                ev = 1;
                for (int i = 0; i < 4; i++) ed[8*i +: 8] = mcc[i] ? a[8*i +: 8] : b[8*i +: 8];
            end
            5'h0B: if (dest != 0) begin
                ev = 1;
                for (int i = 0; i < 2; i++) ed[16*i +: 16] = mcc[i] ? a[16*i +: 16] : b[16*i +: 16];
            end
            default: er = 1'b1;
        endcase
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_dest = dest; op_a = a; op_b = b;
        @(negedge clk);
        op_valid = 1'b0;
        chk(res_valid == ev, tag, 64'(res_valid), 64'(ev));
        chk(rsvd == er, tag, 64'(rsvd), 64'(er));
        chk(ctrl == {4'd0, mcc, 24'd0}, tag, 64'(ctrl), 64'({4'd0, mcc, 24'd0}));
        if (ev) begin
            chk(res_data == ed, tag, 64'(res_data), 64'(ed));
            chk(res_dest == dest, tag, 64'(res_dest), 64'(dest));
        end
    endtask

    logic [7:0]  bv [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h40};
    logic [15:0] hv [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'hFFFE, 16'h1234};

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(ctrl == 0 && !res_valid && !rsvd && res_data == 0, "R8",
            {res_valid, rsvd, res_data, ctrl[29:0]}, 64'd0);
        rst_n = 1'b1;

        // R1 / R4 / R5: byte sweep, unsigned lanes, all three relations, three kinds
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a, b;
                a = {bv[i], bv[(i+1)%8], bv[(i+3)%8], bv[j]};
                b = {bv[j], bv[(j+2)%8], bv[i], bv[j]};
                for (int r = 0; r < 3; r++) begin
                    run_op(5'(r), 5'd1, a, b, "R1");
                    run_op(5'(5'h04 + r), 5'(1 + (i+j)%31), a, b, "R4");
                    run_op(5'(5'h18 + r), 5'd7, b, a, "R5");
                end
            end
        end

        // R2 / R3: halfword signed sweep; upper condition bits must persist
        run_op(5'h00, 5'd0, 32'h11223344, 32'h11223344, "R3");
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int r = 0; r < 3; r++) begin
                    run_op(5'(5'h08 + r), 5'(j), {hv[i], hv[j]}, {hv[j], hv[(i+5)%8]}, (j == 0) ? "R3" : "R2");
                end
            end
        end

        // R6: select under every condition pattern
        for (int p = 0; p < 16; p++) begin
            logic [31:0] a;
            for (int i = 0; i < 4; i++) a[8*i +: 8] = p[i] ? 8'h05 : 8'h06;
            run_op(5'h00, 5'd3, a, 32'h05050505, "R3");
            run_op(5'h03, 5'd9, 32'hA1B2C3D4, 32'h5E6F7081, "R6");
            run_op(5'h0B, 5'd31, 32'hCAFE1234, 32'h0BAD5678, "R6");
        end

        // R7: destination 0 on all result-writing codes
        run_op(5'h00, 5'd0, 32'h0, 32'h0, "R3");
        run_op(5'h18, 5'd0, 32'h0, 32'hFFFFFFFF, "R7");
        run_op(5'h19, 5'd0, 32'h0, 32'hFFFFFFFF, "R7");
        run_op(5'h04, 5'd0, 32'h1, 32'h2, "R7");
        run_op(5'h03, 5'd0, 32'h1, 32'h2, "R7");
        run_op(5'h0B, 5'd0, 32'h1, 32'h2, "R7");

        // R10: every code; unrecognised ones pulse reserved
        for (int c = 0; c < 32; c++) begin
            run_op(5'(c), 5'd4, 32'h80FF0102, 32'h7F000103, "R10");
        end

        // R9: idle cycles produce nothing and keep state
        begin
            logic [31:0] held;
            held = ctrl;
            @(negedge clk); @(negedge clk);
            chk(!res_valid && !rsvd && ctrl == held, "R9", {res_valid, rsvd, ctrl[29:0]}, {2'b00, held[29:0]});
        end
        // R8: bits outside the field still clear after all traffic
        chk((ctrl & 32'hF0FFFFFF) == 0, "R8", 64'(ctrl & 32'hF0FFFFFF), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule